// File: doc/BRIEF.md
# Frame-Rate Hysteresis Clock Selector

This block keeps a video source, which writes into a frame buffer, running at the same average frame rate as the display that reads from it. The source can run from one of two core clocks: a slow one, giving a frame rate just under the display rate, and a fast one, giving a rate just over it. In slow mode the buffer fill level falls steadily. In fast mode it rises steadily. By switching between the two, the average source rate matches the display rate, and the buffer never overruns or underruns.

The fill level is the distance in scan lines between the line the source is producing and the line the display is showing. It is taken modulo the number of lines in a frame, so that it stays correct when either counter wraps at a frame boundary. It is then read as a signed value. Two threshold parameters form a hysteresis band around the working point. Crossing the low threshold selects the fast clock, and crossing the high threshold selects the slow clock. Each change of mode is announced by a one-cycle request pulse on the matching output. An enable input switches the mechanism off, which leaves the core on a fixed slow clock.

Top module: `fr_hyst_sel`

## Requirements
- R1: After reset, `fast_sel`, `req_fast` and `req_slow` are all 0.
- R2: The fill level is `(src_line - dsp_line)` taken modulo `LINES`, in the range 0 to `LINES-1`. A value of `LINES/2` or more is reduced by `LINES`, so the level lies in `[-LINES/2, LINES/2)`.
- R3: While enabled in slow mode, a level strictly below `LOW_TH` makes the design do three things on the next clock edge: set `fast_sel` to 1, raise `req_fast` for exactly one cycle, and leave `req_slow` at 0.
- R4: While enabled in fast mode, a level strictly above `HIGH_TH` makes the design do three things on the next clock edge: clear `fast_sel`, raise `req_slow` for exactly one cycle, and leave `req_fast` at 0.
- R5: While enabled, a level from `LOW_TH` to `HIGH_TH` inclusive keeps the current mode and raises no request. The same holds for a level past the threshold that only pushes further in the direction of the current mode.
- R6: While `enable` is 0, the next clock edge leaves `fast_sel` at 0 and raises neither request, whatever the scan lines are.
- R7: A request pulses only on a cycle in which `fast_sel` has just changed while enabled, and the two requests are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 lets the regulator run; 0 forces a fixed slow clock |
| src_line | input | LW | Scan line the source is generating (0 to LINES-1) |
| dsp_line | input | LW | Scan line the display is showing (0 to LINES-1) |
| fast_sel | output | 1 | Current mode: 1 is the fast clock, 0 is the slow clock |
| req_fast | output | 1 | One-cycle request to switch to the fast clock |
| req_slow | output | 1 | One-cycle request to switch to the slow clock |

`LW` is `$clog2(LINES)`.

## Verification
The bench builds the block with `LINES = 12`, `LOW_TH = -2` and `HIGH_TH = 3`. The signed level then spans only -6 to 5, so a double sweep over every source and display line pair reaches every level in both modes. That includes the wrap cases where the display line is ahead of the source line, both threshold edges, and the values just inside the band. Enable is dropped every ninth cycle, which covers a disable arriving while the design is in fast mode and a request that would otherwise be due.

// File: rtl/fr_hyst_sel.sv
module fr_hyst_sel #(
  parameter int LINES   = 312,
  parameter int LOW_TH  = -40,
  parameter int HIGH_TH = 40,
  localparam int LW     = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [LW-1:0] src_line,
  input  logic [LW-1:0] dsp_line,
  output logic          fast_sel,
  output logic          req_fast,
  output logic          req_slow
);

  localparam int HALF = LINES / 2;

  int level;

  always_comb begin
    level = int'(src_line) - int'(dsp_line);
    if (level < 0) level = level + LINES;
    if (level >= HALF) level = level - LINES;
  end

  wire go_fast = enable && !fast_sel && (level < LOW_TH);
  wire go_slow = enable &&  fast_sel && (level > HIGH_TH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_sel <= 1'b0;
      req_fast <= 1'b0;
      req_slow <= 1'b0;
    end else begin
      req_fast <= go_fast;
      req_slow <= go_slow;
      if (!enable)      fast_sel <= 1'b0;
      else if (go_fast) fast_sel <= 1'b1;
      else if (go_slow) fast_sel <= 1'b0;
    end
  end

  // R7
  reqs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_fast && req_slow));

  // R3
  fast_req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fast |-> (fast_sel && !$past(fast_sel)));

  // R4
  slow_req_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_slow |-> (!fast_sel && $past(fast_sel)));

  // R6
  disable_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fast_sel && !req_fast && !req_slow));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fast |=> !req_fast);

endmodule

// File: tb/fr_hyst_sel_bench.sv
module fr_hyst_sel_bench;

  localparam int L  = 12;
  localparam int LO = -2;
  localparam int HI = 3;
  localparam int W  = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [W-1:0] src_line = '0;
  logic [W-1:0] dsp_line = '0;
  logic fast_sel, req_fast, req_slow;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  fr_hyst_sel #(.LINES(L), .LOW_TH(LO), .HIGH_TH(HI)) u_fr_hyst_sel (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .src_line(src_line), .dsp_line(dsp_line),
    .fast_sel(fast_sel), .req_fast(req_fast), .req_slow(req_slow)
  );

  always #4 clk = ~clk;

  function automatic int lvl(int s, int d);
    int v;
    v = s - d;
    if (v < 0) v += L;
    if (v >= L / 2) v -= L;
    return v;
  endfunction

  task automatic chk(string tag, logic act_f, logic act_rf, logic act_rs,
                     logic e_f, logic e_rf, logic e_rs);
    checks++;
    if ({act_f, act_rf, act_rs} !== {e_f, e_rf, e_rs}) begin
      errors++;
      $display("FAIL %s: fast/req_fast/req_slow = %b%b%b expected %b%b%b",
               tag, act_f, act_rf, act_rs, e_f, e_rf, e_rs);
    end
  endtask

  initial begin
    logic m_f;
    int cyc;
    int lv;
    logic ef, erf, ers;
    repeat (3) @(negedge clk);
    chk("R1 reset", fast_sel, req_fast, req_slow, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    m_f = 1'b0;
    cyc = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int s = 0; s < L; s++) begin
        for (int d = 0; d < L; d++) begin
          src_line = W'(s);
          dsp_line = W'(pass == 0 ? d : (L - 1 - d));
          enable = (cyc % 9) != 8;
          lv = lvl(int'(src_line), int'(dsp_line));
          erf = 1'b0; ers = 1'b0;
          if (!enable) ef = 1'b0;
          else if (!m_f && lv < LO) begin ef = 1'b1; erf = 1'b1; end
          else if (m_f && lv > HI)  begin ef = 1'b0; ers = 1'b1; end
          else ef = m_f;
          @(negedge clk);
          if (!enable)  chk("R6 disabled", fast_sel, req_fast, req_slow, ef, erf, ers);
          else if (erf) chk("R3 to fast (R2 level)", fast_sel, req_fast, req_slow, ef, erf, ers);
          else if (ers) chk("R4 to slow (R2 level)", fast_sel, req_fast, req_slow, ef, erf, ers);
          else          chk("R5 hold R7", fast_sel, req_fast, req_slow, ef, erf, ers);
          m_f = ef;
          cyc++;
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule